// File: doc/BRIEF.md
# Planar Video Memory Access Controller

This block connects an 8-bit processor bus to a video store made of four byte-wide planes: three pixel planes and one attribute plane. It also holds a sixteen-entry, four-bit colour palette. A 16 KB window of the processor address space is decoded when the video-select input is high. Inside that window, one write can update several pixel planes at once. Each enabled plane receives either the processor byte or all-ones. A read returns the bitwise AND of the planes that are both enabled and selected.

A four-bit attribute latch follows accesses to pixel plane 2. On a write to plane 2 the latch is reloaded from the attribute input, unless hold is requested, and the latch value is stored in the attribute plane at the same offset. On a read of plane 2 the latch is loaded from the attribute plane. The latch is always visible on an eight-bit attribute port. When the palette-select flag is set and no pixel plane is enabled, the window accesses the palette instead.

The control has two named states. `ST_CLEAR` is entered on reset and writes zero to every offset of all four planes, one offset per clock, while `busy` is high. The transition "sweep done" happens when the sweep counter reaches the last offset, and moves the machine to `ST_IDLE`. `ST_IDLE` accepts one request per clock and holds no other transition. Reads use registered memory, so each read answers one clock later.

Top module: `pvm_top`

## Requirements
- R1: An access is accepted only when `vid_sel` is high, `addr[15:14]` is 2'b10 and `busy` is low. Any other request changes no plane, palette entry or latch, and a read outside these conditions produces no `rvalid`.
- R2: An accepted read raises `rvalid` for exactly the next clock, with `rdata` valid in that clock. `rdata` is zero whenever `rvalid` is low. If `req_rd` and `req_wr` are both high, only the write is performed.
- R3: The plane offset is `addr[OFS_W-1:0]`. Address bits 13 down to `OFS_W` are ignored, so addresses that differ only in those bits alias.
- R4: On a plane write, `plane_ctl` bits 4, 5 and 6 enable writing planes 0, 1 and 2. For each enabled plane n, `plane_ctl[n]` set stores `wdata`, and clear stores 8'hFF.
- R5: A write with `plane_ctl[6]` set first loads the latch from `attr_in`, unless hold (`mode_ctl[4]`) is set, in which case the latch keeps its value. The write then stores {4'h0, latch} into the attribute plane at the same offset.
- R6: A plane read returns 8'hFF ANDed with plane n for every n in 0..2 where both `plane_ctl[4+n]` and `plane_ctl[n]` are set.
- R7: A plane read with `plane_ctl[6]` and `plane_ctl[2]` both set loads the latch from the low four bits of the attribute plane at that offset.
- R8: `attr_port` is {latch[3], 4'b0000, latch[2:0]}. It shows a write's latch value from the clock after the write, and a read's latch value in the read's `rvalid` clock. It changes at no other time.
- R9: Palette mode applies when (`mode_ctl[2]` or `mode_ctl[3]`) is set and `plane_ctl[6:4]` is zero. In palette mode a write stores `wdata[3:0]` into entry `addr[3:0]`, and a read returns {4'h0, entry}. Neither touches the planes or the latch.
- R10: After reset, `busy` is high for exactly 2**`OFS_W` clocks while every plane offset is cleared to zero. Requests made in that time are ignored. The palette and the latch reset to zero, and `busy` never rises again until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_sel | input | 1 | Video window enable |
| req_rd | input | 1 | Read request, one clock per access |
| req_wr | input | 1 | Write request, one clock per access |
| addr | input | 16 | Processor address |
| wdata | input | 8 | Processor write byte |
| plane_ctl | input | 8 | Plane enables [6:4] and data/all-ones selects [2:0] |
| mode_ctl | input | 8 | Hold flag [4], palette-select [3] or [2] |
| attr_in | input | 4 | Attribute value loaded on plane-2 writes |
| rdata | output | 8 | Read result, valid with rvalid |
| rvalid | output | 1 | Read result strobe |
| attr_port | output | 8 | Latch mapped to bits 7 and 2:0 |
| busy | output | 1 | Power-on clear in progress |

## Verification
The bench builds the block with `OFS_W` = 4, which gives sixteen offsets per plane. At that size the clear sweep can be timed to the exact clock. Every offset can be read under all 64 combinations of plane enables and selects. Address bits 13 down to 4 carry varying values, so aliasing is exercised on every write. Every one of the 128 write-control patterns is applied with changing data, attribute and hold settings, and the result is compared against a plane model kept in the bench.

// File: rtl/pvm_pkg.sv
package pvm_pkg;

    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_IDLE  = 1'b1
    } pvm_state_e;

    localparam int NUM_PIX   = 3;
    localparam int NUM_PLANE = 4;
    localparam int ATTR_IDX  = 3;

    function automatic logic [7:0] attr_map(input logic [3:0] l);
        return {l[3], 4'b0000, l[2:0]};
    endfunction

endpackage

// File: rtl/pvm_plane_ram.sv
module pvm_plane_ram #(
    parameter int OFS_W = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [OFS_W-1:0] waddr,
    input  logic [7:0]       wd,
    input  logic             re,
    input  logic [OFS_W-1:0] raddr,
    output logic [7:0]       q
);
    localparam int DEPTH = 1 << OFS_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wd;
        end
        if (re) begin
            q <= mem[raddr];
        end
    end
endmodule

// File: rtl/pvm_palette.sv
module pvm_palette #(
    parameter int IDX_W = 4,
    parameter int ENT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             re,
    input  logic [IDX_W-1:0] idx,
    input  logic [ENT_W-1:0] wd,
    output logic [ENT_W-1:0] q
);
    localparam int N_ENT = 1 << IDX_W;

    logic [ENT_W-1:0] ent_q [N_ENT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) begin
                ent_q[i] <= '0;
            end
            q <= '0;
        end else begin
            if (we) begin
                ent_q[idx] <= wd;
            end
            if (re) begin
                q <= ent_q[idx];
            end
        end
    end
endmodule

// File: rtl/pvm_ctrl.sv
module pvm_ctrl
    import pvm_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           vid_sel,
    input  logic                           req_rd,
    input  logic                           req_wr,
    input  logic [15:0]                    addr,
    input  logic [7:0]                     wdata,
    input  logic [7:0]                     plane_ctl,
    input  logic [7:0]                     mode_ctl,
    input  logic [3:0]                     attr_in,
    input  logic [NUM_PLANE-1:0][7:0]      pl_q,
    input  logic [3:0]                     pal_q,
    output logic [NUM_PLANE-1:0]           pl_we,
    output logic [NUM_PLANE-1:0][7:0]      pl_wd,
    output logic [OFS_W-1:0]               pl_waddr,
    output logic                           pl_re,
    output logic                           pal_we,
    output logic                           pal_re,
    output logic [7:0]                     rdata,
    output logic                           rvalid,
    output logic [7:0]                     attr_port,
    output logic                           busy
);
    localparam logic [OFS_W-1:0] LAST_OFS = '1;

    pvm_state_e       state_q, state_d;
    logic [OFS_W-1:0] clr_q;

    logic             hit, pal_sel, hold, pal_mode, idle, clearing;
    logic             wr_go, rd_go, wr_attr;
    logic [3:0]       latch_q, latch_view, latch_wr, latch_d;

    logic             rsp_v, rsp_pal, rsp_attr;
    logic [NUM_PIX-1:0] rsp_en;
    logic [7:0]       and_v;

    logic unused_bits;
    assign unused_bits = ^{addr[13:OFS_W], plane_ctl[7], plane_ctl[3],
                           mode_ctl[7:5], mode_ctl[1:0], pl_q[ATTR_IDX][7:4]};

    // decode
    assign hit      = vid_sel && (addr[15:14] == 2'b10);
    assign pal_sel  = mode_ctl[2] | mode_ctl[3];
    assign hold     = mode_ctl[4];
    assign pal_mode = pal_sel && (plane_ctl[6:4] == 3'b000);
    assign idle     = (state_q == ST_IDLE);
    assign clearing = (state_q == ST_CLEAR);
    assign wr_go    = idle && req_wr && hit;
    assign rd_go    = idle && req_rd && !req_wr && hit;
    assign wr_attr  = wr_go && !pal_mode && plane_ctl[4 + ATTR_IDX - 1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            clr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (clearing) begin
                clr_q <= clr_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (clr_q == LAST_OFS) state_d = ST_IDLE;
            ST_IDLE:  state_d = ST_IDLE;
            default:  state_d = ST_CLEAR;
        endcase
    end

    // latch path: a read response overrides the stored latch in its clock
    assign latch_view = (rsp_v && rsp_attr) ? pl_q[ATTR_IDX][3:0] : latch_q;
    assign latch_wr   = hold ? latch_view : attr_in;
    assign latch_d    = wr_attr ? latch_wr : latch_view;

    // outputs towards the memories
    always_comb begin
        pl_we    = '0;
        pl_wd    = '0;
        pl_waddr = addr[OFS_W-1:0];
        pl_re    = 1'b0;
        pal_we   = 1'b0;
        pal_re   = 1'b0;
        unique case (state_q)
            ST_CLEAR: begin
                pl_we    = '1;
                pl_waddr = clr_q;
            end
            ST_IDLE: begin
                pal_we = wr_go && pal_mode;
                pal_re = rd_go && pal_mode;
                pl_re  = rd_go && !pal_mode;
                for (int n = 0; n < NUM_PIX; n++) begin
                    pl_we[n] = wr_go && !pal_mode && plane_ctl[4 + n];
                    pl_wd[n] = plane_ctl[n] ? wdata : 8'hFF;
                end
                pl_we[ATTR_IDX] = wr_attr;
                pl_wd[ATTR_IDX] = {4'h0, latch_wr};
            end
            default: ;
        endcase
    end

    // read context and latch registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_v    <= 1'b0;
            rsp_pal  <= 1'b0;
            rsp_attr <= 1'b0;
            rsp_en   <= '0;
            latch_q  <= '0;
        end else begin
            rsp_v    <= rd_go;
            rsp_pal  <= pal_mode;
            rsp_attr <= rd_go && !pal_mode && plane_ctl[6] && plane_ctl[2];
            for (int n = 0; n < NUM_PIX; n++) begin
                rsp_en[n] <= plane_ctl[4 + n] && plane_ctl[n];
            end
            latch_q  <= latch_d;
        end
    end

    // read combine
    always_comb begin
        and_v = 8'hFF;
        for (int n = 0; n < NUM_PIX; n++) begin
            if (rsp_en[n]) begin
                and_v = and_v & pl_q[n];
            end
        end
    end

    assign rdata     = !rsp_v ? 8'h00 : (rsp_pal ? {4'h0, pal_q} : and_v);
    assign rvalid    = rsp_v;
    assign attr_port = attr_map(latch_view);
    assign busy      = clearing;

    // R10: clear happens once per reset
    a_r10_busy_once: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy);

    // R10: no responses during the clear
    a_r10_quiet_clear: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rvalid);

    // R2 / R1: every strobe traces back to an accepted read one clock earlier
    a_r2_rvalid_src: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(req_rd && !req_wr && vid_sel && addr[15:14] == 2'b10 && !busy));

    // R5: a held plane-2 write keeps the port steady
    a_r5_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_attr && hold && !rvalid) |=> $stable(attr_port));

    // R8: the port moves only on a plane-2 write or a read response
    a_r8_port_moves: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(attr_port) |-> (rvalid || $past(wr_attr)));
endmodule

// File: rtl/pvm_top.sv
module pvm_top
    import pvm_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vid_sel,
    input  logic        req_rd,
    input  logic        req_wr,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    input  logic [7:0]  plane_ctl,
    input  logic [7:0]  mode_ctl,
    input  logic [3:0]  attr_in,
    output logic [7:0]  rdata,
    output logic        rvalid,
    output logic [7:0]  attr_port,
    output logic        busy
);
    logic [NUM_PLANE-1:0][7:0] pl_q;
    logic [NUM_PLANE-1:0][7:0] pl_wd;
    logic [NUM_PLANE-1:0]      pl_we;
    logic [OFS_W-1:0]          pl_waddr;
    logic                      pl_re;
    logic                      pal_we, pal_re;
    logic [3:0]                pal_q;

    pvm_ctrl #(.OFS_W(OFS_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .vid_sel   (vid_sel),
        .req_rd    (req_rd),
        .req_wr    (req_wr),
        .addr      (addr),
        .wdata     (wdata),
        .plane_ctl (plane_ctl),
        .mode_ctl  (mode_ctl),
        .attr_in   (attr_in),
        .pl_q      (pl_q),
        .pal_q     (pal_q),
        .pl_we     (pl_we),
        .pl_wd     (pl_wd),
        .pl_waddr  (pl_waddr),
        .pl_re     (pl_re),
        .pal_we    (pal_we),
        .pal_re    (pal_re),
        .rdata     (rdata),
        .rvalid    (rvalid),
        .attr_port (attr_port),
        .busy      (busy)
    );

    for (genvar g = 0; g < NUM_PLANE; g++) begin : g_plane
        pvm_plane_ram #(.OFS_W(OFS_W)) u_ram (
            .clk   (clk),
            .we    (pl_we[g]),
            .waddr (pl_waddr),
            .wd    (pl_wd[g]),
            .re    (pl_re),
            .raddr (addr[OFS_W-1:0]),
            .q     (pl_q[g])
        );
    end

    pvm_palette #(.IDX_W(4), .ENT_W(4)) u_pal (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pal_we),
        .re    (pal_re),
        .idx   (addr[3:0]),
        .wd    (wdata[3:0]),
        .q     (pal_q)
    );
endmodule

// File: tb/test_pvm_top.sv
`timescale 1ns/1ps
module test_pvm_top;
    localparam int OFS_W = 4;
    localparam int DEPTH = 1 << OFS_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vid_sel = 1'b1;
    logic        req_rd = 1'b0;
    logic        req_wr = 1'b0;
    logic [15:0] addr = 16'h0;
    logic [7:0]  wdata = 8'h0;
    logic [7:0]  plane_ctl = 8'h77;
    logic [7:0]  mode_ctl = 8'h00;
    logic [3:0]  attr_in = 4'h0;
    logic [7:0]  rdata;
    logic        rvalid;
    logic [7:0]  attr_port;
    logic        busy;

    always #4 clk = ~clk;

    pvm_top #(.OFS_W(OFS_W)) i_pvm_top (
        .clk(clk), .rst_n(rst_n), .vid_sel(vid_sel), .req_rd(req_rd), .req_wr(req_wr),
        .addr(addr), .wdata(wdata), .plane_ctl(plane_ctl), .mode_ctl(mode_ctl),
        .attr_in(attr_in), .rdata(rdata), .rvalid(rvalid), .attr_port(attr_port), .busy(busy)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    bit m_busy = 1'b0;
    logic [7:0] m_pl [4][DEPTH];
    logic [3:0] m_pal [16];
    logic [3:0] m_latch = 4'h0;

    function automatic logic [7:0] port_of(input logic [3:0] l);
        return {l[3], 4'b0000, l[2:0]};
    endfunction

    function automatic bit m_pal_mode();
        return (mode_ctl[2] | mode_ctl[3]) && (plane_ctl[6:4] == 3'b000);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [7:0] d, input bit both);
        bit ok;
        int o;
        addr = a; wdata = d; req_wr = 1'b1; req_rd = both;
        ok = vid_sel && (a[15:14] == 2'b10) && !m_busy;
        o = int'(a[OFS_W-1:0]);
        @(posedge clk);
        @(negedge clk);
        req_wr = 1'b0; req_rd = 1'b0;
        if (ok) begin
            if (m_pal_mode()) begin
                m_pal[a[3:0]] = d[3:0];
            end else begin
                for (int n = 0; n < 3; n++) begin
                    if (plane_ctl[4+n]) m_pl[n][o] = plane_ctl[n] ? d : 8'hFF;
                end
                if (plane_ctl[6]) begin
                    if (!mode_ctl[4]) m_latch = attr_in;
                    m_pl[3][o] = {4'h0, m_latch};
                end
            end
        end
        if (both) chk("R2 write wins, no rvalid", {7'b0, rvalid}, 8'h00);
        chk("R8 R5 attr_port after write", attr_port, port_of(m_latch));
    endtask

    task automatic do_rd(input logic [15:0] a, input string tag);
        bit ok;
        int o;
        logic [7:0] ev;
        addr = a; req_rd = 1'b1;
        ok = vid_sel && (a[15:14] == 2'b10) && !m_busy;
        o = int'(a[OFS_W-1:0]);
        ev = 8'h00;
        if (ok) begin
            if (m_pal_mode()) begin
                ev = {4'h0, m_pal[a[3:0]]};
            end else begin
                ev = 8'hFF;
                for (int n = 0; n < 3; n++) begin
                    if (plane_ctl[4+n] && plane_ctl[n]) ev = ev & m_pl[n][o];
                end
                if (plane_ctl[6] && plane_ctl[2]) m_latch = m_pl[3][o][3:0];
            end
        end
        @(posedge clk);
        @(negedge clk);
        req_rd = 1'b0;
        chk({tag, " R1 R2 rvalid"}, {7'b0, rvalid}, {7'b0, ok});
        chk({tag, " rdata"}, rdata, ev);
        chk("R7 R8 attr_port in response", attr_port, port_of(m_latch));
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        int cnt;
        for (int n = 0; n < 4; n++)
            for (int o = 0; o < DEPTH; o++) m_pl[n][o] = 8'h00;
        for (int i = 0; i < 16; i++) m_pal[i] = 4'h0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk("R10 busy after reset", {7'b0, busy}, 8'h01);
        chk("R10 rvalid after reset", {7'b0, rvalid}, 8'h00);
        chk("R10 attr_port after reset", attr_port, 8'h00);

        // R10: a write during the clear is dropped
        m_busy = 1'b1;
        attr_in = 4'hF;
        do_wr(16'h8003, 8'h5A, 1'b0);
        cnt = 1;
        while (busy && cnt < 100) begin
            @(negedge clk);
            cnt++;
        end
        m_busy = 1'b0;
        chk("R10 clear length", 8'(cnt), 8'(DEPTH));

        // R10: all planes read back zero
        plane_ctl = 8'h77;
        for (int o = 0; o < DEPTH; o++) do_rd(16'h8000 | 16'(o), "R10 cleared");

        // R4 R5 R3: every write-control pattern, aliased addresses
        for (int pc = 0; pc < 128; pc++) begin
            logic [15:0] a;
            a = 16'h8000 | 16'(pc << 4) | 16'(pc & 15);
            plane_ctl = 8'(pc);
            mode_ctl  = {3'(pc), (pc % 5 == 0), 2'b00, 2'(pc)};
            attr_in   = 4'(pc * 3 + 1);
            do_wr(a, 8'(pc * 37 + 11), 1'b0);
            plane_ctl = 8'((pc * 11) & 8'h77);
            do_rd(16'h8000 | 16'((pc * 7) << 4) | 16'(pc & 15), "R3 R4 R6 readback");
        end

        // R6 R7: every enable/select combination at every offset
        mode_ctl = 8'h00;
        for (int o = 0; o < DEPTH; o++) begin
            for (int rc = 0; rc < 64; rc++) begin
                plane_ctl = {1'b0, 3'(rc >> 3), 1'b0, 3'(rc)};
                do_rd(16'h8000 | 16'(o) | 16'((rc & 3) << 12), "R6 sweep");
            end
        end

        // R9: palette through both select bits
        for (int k = 0; k < 2; k++) begin
            mode_ctl  = k ? 8'h08 : 8'h04;
            plane_ctl = 8'h07;
            attr_in   = 4'h9;
            for (int i = 0; i < 16; i++)
                do_wr(16'h8000 | 16'(i << 8) | 16'(i), 8'((i * 8'h31) ^ 8'hA0 ^ k), 1'b0);
            for (int i = 0; i < 16; i++)
                do_rd(16'h8000 | 16'(i), "R9 palette");
        end
        // R9: planes and latch untouched by palette traffic
        mode_ctl  = 8'h04;
        plane_ctl = 8'h77;
        for (int o = 0; o < DEPTH; o++) do_rd(16'h8000 | 16'(o), "R9 planes intact");

        // R1: outside the window or with video deselected
        mode_ctl = 8'h00;
        plane_ctl = 8'h77;
        attr_in = 4'h6;
        vid_sel = 1'b0;
        do_wr(16'h8001, 8'h12, 1'b0);
        do_rd(16'h8001, "R1 deselected");
        vid_sel = 1'b1;
        do_wr(16'h4001, 8'h34, 1'b0);
        do_wr(16'hC001, 8'h56, 1'b0);
        do_rd(16'h4001, "R1 below window");
        do_rd(16'hC001, "R1 above window");
        do_rd(16'h8001, "R1 contents unchanged");

        // R2: read and write in the same clock
        attr_in = 4'hB;
        do_wr(16'h8002, 8'hC3, 1'b1);
        do_rd(16'h8002, "R2 after joint request");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule